// File: doc/BRIEF.md
# Programmable raster timing generator

This block produces the horizontal and vertical timing of a raster display from a handful of configuration words. Every horizontal interval is expressed in characters of 8 pixels and every vertical interval in scanlines. Both axes step through the same four phases in a fixed order: sync, display start (back porch), active display and display end (front porch). At the end of display end the axis returns to sync. One clock is one pixel.

The block outputs a pixel counter within the line and a line counter within the frame. It also drives active-high sync strobes, active-display enables for each axis and for both together, and a one-cycle pulse when vertical active display ends. A further one-cycle pulse marks the start of a line that matches a compare value. Background scroll values from the host are captured once per line, so the fetch logic downstream always sees values that stay constant across the line. The timing words are shadowed once per frame, so a frame that is already running always completes with the geometry it started with.

All pins are plain level control and status signals. No streamed data crosses the boundary, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `rtg_raster_timer`

## Requirements
- R1: While rst_n is low every output is 0. The first rising edge after release captures the configuration words and the scroll inputs. The cycle that follows that edge is pixel 0 of line 0 of the first frame.
- R2: Horizontal interval lengths in characters are decoded as follows. Sync is h_sync_cfg[4:0]+1, display start is h_sync_cfg[14:8]+1, active display is h_disp_cfg[6:0]+1 and display end is h_disp_cfg[14:8]+1. The line length is 8 times their sum, and pix_x counts 0 up to that length minus 1 before wrapping to 0.
- R3: hsync is 1 exactly during the sync-phase pixels at the start of each line, and h_active is 1 exactly during the active-display pixels. The horizontal phases occur in the order sync, start, display, end.
- R4: Vertical interval lengths in lines are decoded as follows. Sync is v_sync_cfg[4:0]+1, display start is v_sync_cfg[15:8]+2, active display is v_disp_cfg[8:0]+1 and display end is v_end_cfg[7:0]. A display end of 0 sends the last active line straight into sync. line_y counts lines from 0 at the first sync line.
- R5: vsync is 1 on every line of the vertical sync phase. v_active is 1 on every line of the vertical active phase. disp_active is h_active AND v_active. line_y changes only on the cycle where pix_x is 0.
- R6: vblank_pulse is 1 for exactly one cycle, at pixel 0 of the first line after the last active-display line. When display end is 0, that line is line 0 of the next frame.
- R7: raster_hit is 1 for one cycle, at pixel 0 of the line whose line_y equals raster_cmp, while raster_irq_en is 1. It stays 0 while raster_irq_en is 0.
- R8: line_scroll_x and line_scroll_y take the values of scroll_x and scroll_y on the edge that begins each line. A change in the middle of a line appears only from the next line.
- R9: The timing words are captured only on the edge that begins a frame. A change in the middle of a frame leaves the rest of that frame unchanged and applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sync_cfg | input | 16 | Horizontal sync width-1 [4:0], display start-1 [14:8] |
| h_disp_cfg | input | 16 | Horizontal display width-1 [6:0], display end-1 [14:8] |
| v_sync_cfg | input | 16 | Vertical sync width-1 [4:0], display start-2 [15:8] |
| v_disp_cfg | input | 16 | Vertical display lines-1 [8:0] |
| v_end_cfg | input | 16 | Vertical display end lines [7:0] |
| raster_cmp | input | 11 | Line number that raises raster_hit |
| raster_irq_en | input | 1 | Enables raster_hit |
| scroll_x | input | 10 | Host background X scroll |
| scroll_y | input | 9 | Host background Y scroll |
| pix_x | output | 12 | Pixel index within the line |
| line_y | output | 11 | Line index within the frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| h_active | output | 1 | Horizontal active display |
| v_active | output | 1 | Vertical active display |
| disp_active | output | 1 | Both axes active |
| vblank_pulse | output | 1 | One-cycle end-of-active-display pulse |
| raster_hit | output | 1 | One-cycle line-match pulse |
| line_scroll_x | output | 10 | X scroll captured for the current line |
| line_scroll_y | output | 9 | Y scroll captured for the current line |

## Verification
Every output except raster_hit comes from a register and reflects the state that the previous edge set up. raster_hit also follows raster_irq_en within the same cycle. A scroll change made inside a line is due at pixel 0 of the next line, and a timing-word change is due at pixel 0 of the next frame. The bench numbers its cycles from the edge that begins the first frame. For every cycle it computes the expected counters and strobes from the decoded interval lengths, and it applies any input change just after a rising edge. The monitor compares all outputs at the falling edge of every cycle. The run covers two geometries: one with a non-zero display end and one with a zero display end. The mid-line scroll change, the mid-frame timing change and the disabling of the compare each land at a known cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_START = 2'd1,
    PH_DISP  = 2'd2,
    PH_END   = 2'd3
  } rtg_phase_e;

  // Phase that follows p; an empty end phase is skipped.
  function automatic rtg_phase_e rtg_succ(rtg_phase_e p, logic end_empty);
    case (p)
      PH_SYNC:  rtg_succ = PH_START;
      PH_START: rtg_succ = PH_DISP;
      PH_DISP:  rtg_succ = end_empty ? PH_SYNC : PH_END;
      default:  rtg_succ = PH_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/rtg_line_latch.sv
module rtg_line_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/rtg_phase_seq.sv
module rtg_phase_seq
  import rtg_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_start,
  input  logic [CW-1:0] len_disp,
  input  logic [CW-1:0] len_end,
  output rtg_phase_e    phase,
  output logic          wrap,
  output logic          leave_disp
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_cur;
  logic          at_end;
  logic          end_empty;
  rtg_phase_e    nxt;

  always_comb begin
    case (phase)
      PH_SYNC:  len_cur = len_sync;
      PH_START: len_cur = len_start;
      PH_DISP:  len_cur = len_disp;
      default:  len_cur = len_end;
    endcase
    end_empty  = (len_end == '0);
    at_end     = (cnt == len_cur - CW'(1));
    nxt        = rtg_succ(phase, end_empty);
    wrap       = step && at_end && (nxt == PH_SYNC);
    leave_disp = step && at_end && (phase == PH_DISP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_SYNC;
    end else if (step) begin
      if (at_end) begin
        cnt   <= '0;
        phase <= nxt;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len_cur);

  p_phase_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase == rtg_succ($past(phase), $past(len_end) == '0)));

  p_step_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase));
endmodule

// File: rtl/rtg_raster_timer.sv
module rtg_raster_timer
  import rtg_pkg::*;
#(
  parameter int PIX_W      = 12,
  parameter int LINE_W     = 11,
  parameter int SX_W       = 10,
  parameter int SY_W       = 9,
  parameter int CHAR_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       h_sync_cfg,
  input  logic [15:0]       h_disp_cfg,
  input  logic [15:0]       v_sync_cfg,
  input  logic [15:0]       v_disp_cfg,
  input  logic [15:0]       v_end_cfg,
  input  logic [LINE_W-1:0] raster_cmp,
  input  logic              raster_irq_en,
  input  logic [SX_W-1:0]   scroll_x,
  input  logic [SY_W-1:0]   scroll_y,
  output logic [PIX_W-1:0]  pix_x,
  output logic [LINE_W-1:0] line_y,
  output logic              hsync,
  output logic              vsync,
  output logic              h_active,
  output logic              v_active,
  output logic              disp_active,
  output logic              vblank_pulse,
  output logic              raster_hit,
  output logic [SX_W-1:0]   line_scroll_x,
  output logic [SY_W-1:0]   line_scroll_y
);
  localparam int NCFG = 5;
  localparam int HCW  = 8;   // up to 128 characters per phase
  localparam int VCW  = 10;  // up to 512 lines per phase
  localparam int SUBW = CHAR_SHIFT;

  logic              primed;
  logic [SUBW-1:0]   sub;
  logic              h_step, h_wrap, h_leave, v_wrap, v_leave;
  logic              cfg_load, scr_load;
  rtg_phase_e        h_ph, v_ph;
  logic [15:0]       cfg_raw [NCFG];
  logic [15:0]       cfg_sh  [NCFG];
  logic [HCW-1:0]    hl_sync, hl_start, hl_disp, hl_end;
  logic [VCW-1:0]    vl_sync, vl_start, vl_disp, vl_end;
  logic              unused_cfg;

  always_comb begin
    cfg_raw[0] = h_sync_cfg;
    cfg_raw[1] = h_disp_cfg;
    cfg_raw[2] = v_sync_cfg;
    cfg_raw[3] = v_disp_cfg;
    cfg_raw[4] = v_end_cfg;
  end

  assign cfg_load = !primed || v_wrap;
  assign scr_load = !primed || h_wrap;

  for (genvar g = 0; g < NCFG; g++) begin : g_shadow
    rtg_line_latch #(.W(16)) u_cfg (
      .clk (clk), .rst_n (rst_n), .load (cfg_load),
      .d (cfg_raw[g]), .q (cfg_sh[g])
    );
  end

  rtg_line_latch #(.W(SX_W)) u_scx (
    .clk (clk), .rst_n (rst_n), .load (scr_load), .d (scroll_x), .q (line_scroll_x)
  );
  rtg_line_latch #(.W(SY_W)) u_scy (
    .clk (clk), .rst_n (rst_n), .load (scr_load), .d (scroll_y), .q (line_scroll_y)
  );

  // Field decode with the stored offsets
  always_comb begin
    hl_sync  = HCW'(cfg_sh[0][4:0])  + HCW'(1);
    hl_start = HCW'(cfg_sh[0][14:8]) + HCW'(1);
    hl_disp  = HCW'(cfg_sh[1][6:0])  + HCW'(1);
    hl_end   = HCW'(cfg_sh[1][14:8]) + HCW'(1);
    vl_sync  = VCW'(cfg_sh[2][4:0])  + VCW'(1);
    vl_start = VCW'(cfg_sh[2][15:8]) + VCW'(2);
    vl_disp  = VCW'(cfg_sh[3][8:0])  + VCW'(1);
    vl_end   = VCW'(cfg_sh[4][7:0]);
  end

  assign unused_cfg = ^{cfg_sh[0][15], cfg_sh[0][7:5], cfg_sh[1][15], cfg_sh[1][7],
                        cfg_sh[2][7:5], cfg_sh[3][15:9], cfg_sh[4][15:8], h_leave};

  assign h_step = primed && (sub == '1);

  rtg_phase_seq #(.CW(HCW)) u_hseq (
    .clk (clk), .rst_n (rst_n), .step (h_step),
    .len_sync (hl_sync), .len_start (hl_start), .len_disp (hl_disp), .len_end (hl_end),
    .phase (h_ph), .wrap (h_wrap), .leave_disp (h_leave)
  );

  rtg_phase_seq #(.CW(VCW)) u_vseq (
    .clk (clk), .rst_n (rst_n), .step (h_wrap),
    .len_sync (vl_sync), .len_start (vl_start), .len_disp (vl_disp), .len_end (vl_end),
    .phase (v_ph), .wrap (v_wrap), .leave_disp (v_leave)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed       <= 1'b0;
      sub          <= '0;
      pix_x        <= '0;
      line_y       <= '0;
      vblank_pulse <= 1'b0;
    end else begin
      primed       <= 1'b1;
      vblank_pulse <= v_leave;
      if (primed) begin
        sub   <= sub + SUBW'(1);
        pix_x <= h_wrap ? '0 : pix_x + PIX_W'(1);
        if (h_wrap) line_y <= v_wrap ? '0 : line_y + LINE_W'(1);
      end
    end
  end

  assign hsync       = primed && (h_ph == PH_SYNC);
  assign vsync       = primed && (v_ph == PH_SYNC);
  assign h_active    = primed && (h_ph == PH_DISP);
  assign v_active    = primed && (v_ph == PH_DISP);
  assign disp_active = h_active && v_active;
  assign raster_hit  = primed && raster_irq_en && (pix_x == '0) && (line_y == raster_cmp);

  p_vblank_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |=> !vblank_pulse);

  p_vblank_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |-> (pix_x == '0 && !v_active));

  p_hit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raster_hit |=> !raster_hit);

  p_line_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_y != $past(line_y)) |-> (pix_x == '0));

  p_scroll_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> ($stable(line_scroll_x) && $stable(line_scroll_y)));

  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0 || line_y != '0) |-> $stable(cfg_sh[0]) && $stable(cfg_sh[2]));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !primed |-> (!hsync && !vsync && !raster_hit && pix_x == '0));
endmodule

// File: tb/tb_rtg_raster_timer.sv
module tb_rtg_raster_timer;
  localparam int NT = 1200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_sync_cfg, h_disp_cfg, v_sync_cfg, v_disp_cfg, v_end_cfg;
  logic [10:0] raster_cmp;
  logic        raster_irq_en;
  logic [9:0]  scroll_x;
  logic [8:0]  scroll_y;
  logic [11:0] pix_x;
  logic [10:0] line_y;
  logic        hsync, vsync, h_active, v_active, disp_active, vblank_pulse, raster_hit;
  logic [9:0]  line_scroll_x;
  logic [8:0]  line_scroll_y;

  always #4 clk = ~clk;

  rtg_raster_timer dut (
    .clk (clk), .rst_n (rst_n),
    .h_sync_cfg (h_sync_cfg), .h_disp_cfg (h_disp_cfg), .v_sync_cfg (v_sync_cfg),
    .v_disp_cfg (v_disp_cfg), .v_end_cfg (v_end_cfg),
    .raster_cmp (raster_cmp), .raster_irq_en (raster_irq_en),
    .scroll_x (scroll_x), .scroll_y (scroll_y),
    .pix_x (pix_x), .line_y (line_y), .hsync (hsync), .vsync (vsync),
    .h_active (h_active), .v_active (v_active), .disp_active (disp_active),
    .vblank_pulse (vblank_pulse), .raster_hit (raster_hit),
    .line_scroll_x (line_scroll_x), .line_scroll_y (line_scroll_y)
  );

  // Geometry index 0 (first frame) and 1 (after the mid-frame change), decoded per R2/R4
  int HSW [2] = '{1, 2};
  int HDS [2] = '{1, 1};
  int HDW [2] = '{2, 1};
  int HDE [2] = '{1, 2};
  int VSW [2] = '{1, 2};
  int VDS [2] = '{2, 2};
  int VDW [2] = '{3, 2};
  int VDE [2] = '{1, 0};

  typedef struct {
    int t; int px; int ln;
    bit hs; bit vs; bit ha; bit va; bit da; bit vb; bit hit;
    int sx; int sy;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   reported = 0;

  function automatic exp_t predict(int t);
    exp_t e;
    int c, pc, ft, llen;
    if (t < 280)      begin c = 0; pc = -1; ft = t;                 end
    else if (t < 568) begin c = 1; pc = 0;  ft = t - 280;           end
    else              begin c = 1; pc = 1;  ft = (t - 568) % 288;   end
    llen = 8 * (HSW[c] + HDS[c] + HDW[c] + HDE[c]);
    e.t  = t;
    e.px = ft % llen;
    e.ln = ft / llen;
    e.hs = e.px < 8 * HSW[c];
    e.ha = (e.px >= 8 * (HSW[c] + HDS[c])) && (e.px < 8 * (HSW[c] + HDS[c] + HDW[c]));
    e.vs = e.ln < VSW[c];
    e.va = (e.ln >= VSW[c] + VDS[c]) && (e.ln < VSW[c] + VDS[c] + VDW[c]);
    e.da = e.ha && e.va;
    e.vb = (e.px == 0) && ((VDE[c] > 0 && e.ln == VSW[c] + VDS[c] + VDW[c]) ||
                           (e.ln == 0 && pc >= 0 && VDE[pc] == 0));
    e.hit = (e.px == 0) && (e.ln == 4) && (t < 200);
    e.sx = (t < 80) ? 5 : 9;
    e.sy = (t < 80) ? 7 : 3;
    return e;
  endfunction

  task automatic chk(string tag, int t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: loads the scoreboard and applies stimulus just after rising edges
  initial begin
    h_sync_cfg = 16'h0000; h_disp_cfg = 16'h0001;
    v_sync_cfg = 16'h0000; v_disp_cfg = 16'h0002; v_end_cfg = 16'h0001;
    raster_cmp = 11'd4; raster_irq_en = 1'b1;
    scroll_x = 10'd5; scroll_y = 9'd7;
    for (int t = 0; t < NT; t++) sb_q.push_back(predict(t));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset hsync", -1, int'(hsync), 0);
    chk("R1 reset vsync", -1, int'(vsync), 0);
    chk("R1 reset disp_active", -1, int'(disp_active), 0);
    chk("R1 reset pix_x", -1, int'(pix_x), 0);
    chk("R1 reset raster_hit", -1, int'(raster_hit), 0);
    chk("R1 reset vblank", -1, int'(vblank_pulse), 0);
    rst_n = 1'b1;
    @(posedge clk);  // capture edge: state 0 follows
    for (int t = 0; t < NT; t++) begin
      #1;
      if (t == 50) begin  // mid-line scroll change, due at t=80 (R8)
        scroll_x = 10'd9; scroll_y = 9'd3;
      end
      if (t == 100) begin  // mid-frame geometry change, due at t=280 (R9)
        h_sync_cfg = 16'h0001; h_disp_cfg = 16'h0100;
        v_sync_cfg = 16'h0001; v_disp_cfg = 16'h0001; v_end_cfg = 16'h0000;
      end
      if (t == 200) raster_irq_en = 1'b0;  // compare disabled (R7)
      @(posedge clk);
    end
  end

  // Monitor: pops one expected item per cycle and compares at the falling edge
  initial begin
    exp_t e;
    string ptag;
    @(posedge rst_n);
    @(posedge clk);
    while (sb_q.size() > 0) begin
      @(negedge clk);
      e = sb_q.pop_front();
      ptag = (e.t == 0) ? "R1 pix_x" : ((e.t >= 100 && e.t < 568) ? "R9 pix_x" : "R2 pix_x");
      chk(ptag, e.t, int'(pix_x), e.px);
      chk("R4 line_y", e.t, int'(line_y), e.ln);
      chk("R3 hsync", e.t, int'(hsync), int'(e.hs));
      chk("R3 h_active", e.t, int'(h_active), int'(e.ha));
      chk("R5 vsync", e.t, int'(vsync), int'(e.vs));
      chk("R5 v_active", e.t, int'(v_active), int'(e.va));
      chk("R5 disp_active", e.t, int'(disp_active), int'(e.da));
      chk("R6 vblank_pulse", e.t, int'(vblank_pulse), int'(e.vb));
      chk("R7 raster_hit", e.t, int'(raster_hit), int'(e.hit));
      chk("R8 line_scroll_x", e.t, int'(line_scroll_x), e.sx);
      chk("R8 line_scroll_y", e.t, int'(line_scroll_y), e.sy);
    end
    done = 1;
    finish_run();
  end

  // Watchdog
  initial begin
    repeat (NT + 2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", sb_q.size(), 0);
    end
    finish_run();
  end
endmodule